// File: doc/BRIEF.md
# Local Command Message Sequencer

This block is a built-in test source for a broadcast-command consumer. A host fills a table of 32 commands, each a subaddress byte and a data byte, and sets a start delay. When the host selects internal mode, the sequencer replays the table as a stream of one-cycle message strobes. The stream takes the place of the messages that normally come from the external decoder. Playback runs once per start in single-shot mode, or loops for as long as internal mode stays selected in repeating mode.

The host reaches the control word, the delay and the table through a small register bus. Writes take effect on a clock edge and reads are combinational. The message output always goes through a source selector, so the consumers downstream see one interface whichever source is active.

Top module: `local_cmd_seq`

## Requirements
- R1: After reset the control word is 0 (external source, repeating playback), the delay reads 0 and every table entry reads 0. The message outputs follow the external inputs.
- R2: While control bit 0 is 0, `msg_valid`, `msg_sub` and `msg_data` equal `ext_valid`, `ext_sub` and `ext_data` in the same cycle.
- R3: Register layout (byte addresses): control at 0x00 uses bits [1:0], where bit 0 = 1 selects the internal source and bit 1 = 1 selects single-shot. The delay is at 0x04 in bits [11:0]. Table entry k is at 0x80 + 4k, with the subaddress in [15:8] and the data in [7:0]. Every register reads back what was written, and bits that are not implemented read 0.
- R4: A pass starts on the clock edge after the edge that accepted the start write. It waits delay+1 cycles. If the start write lands on edge E, the first strobe is visible in the cycle after edge E+D+2, and `msg_valid` is low in the cycles after edges E+1 through E+D+1.
- R5: A pass gives 32 strobes on consecutive cycles, carrying table entries 0 to 31 in order.
- R6: In single-shot mode the sequencer goes idle after entry 31. It sends no further strobes while internal mode stays selected, even if `ext_valid` is high.
- R7: A control write with bits [1:0] = 2'b11 while internal mode is already selected is a start request. It begins a new pass, and one that arrives during a pass restarts it from the delay phase.
- R8: In repeating mode, after entry 31 a new pass begins at once. It waits delay+1 cycles, then sends entries 0 to 31 again.
- R9: A control write that clears bit 0 stops the sequencer. In the cycle after that edge the outputs already equal the external inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 40 MHz-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data for `bus_addr` (combinational) |
| ext_valid | input | 1 | External message strobe |
| ext_sub | input | 8 | External message subaddress |
| ext_data | input | 8 | External message data |
| msg_valid | output | 1 | Selected message strobe |
| msg_sub | output | 8 | Selected message subaddress |
| msg_data | output | 8 | Selected message data |

## Verification
The assertions assume that table addresses are word-aligned. They also assume that the host bus is quiet in the cycle after reset is released, so the history used by `$past` starts clean. The bench writes only at aligned addresses, and it drives every bus and external input at the falling edge, so each write lands on exactly one rising edge. Start requests, restarts and stops are issued at counted positions inside a pass, and the bench checks outputs at the falling edge only after the inputs have settled.

// File: rtl/lcs_pkg.sv
// Package: shared types for the local command sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package lcs_pkg;

    // Sequencer phase: idle, counting the start delay, or sending entries.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } seq_state_t;

    // Byte addresses of the two scalar registers.
    localparam logic [7:0] ADR_CTRL  = 8'h00;
    localparam logic [7:0] ADR_DELAY = 8'h04;

endpackage

// File: rtl/lcs_regs.sv
// Register file: control word, start delay and the command table.
// Assumes N_ENT is a power of two. The table occupies the upper half of
// the address space (base N_ENT*4, word stride 4); the lower half holds
// the scalar registers. Reads are combinational.
module lcs_regs #(
    parameter int N_ENT  = 32,
    parameter int BYTE_W = 8,
    parameter int DLY_W  = 12,
    parameter int ADDR_W = $clog2(N_ENT * 8)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [2*BYTE_W-1:0]        wdata,
    output logic [2*BYTE_W-1:0]        rdata,
    output logic                       mode_int,
    output logic                       single,
    output logic                       start,
    output logic [DLY_W-1:0]           dly,
    input  logic [$clog2(N_ENT)-1:0]   seq_idx,
    output logic [2*BYTE_W-1:0]        seq_entry
);
    import lcs_pkg::*;

    localparam int WORD_W = 2 * BYTE_W;
    localparam int IDX_W  = $clog2(N_ENT);

    logic [WORD_W-1:0] tbl [N_ENT];
    logic              hit_tbl, hit_ctrl, hit_dly;
    logic [IDX_W-1:0]  wr_idx;

    // Address decode for both read and write.
    always_comb begin
        hit_tbl  = addr[ADDR_W-1] && (addr[1:0] == 2'b00);
        hit_ctrl = (addr == ADDR_W'(ADR_CTRL));
        hit_dly  = (addr == ADDR_W'(ADR_DELAY));
        wr_idx   = addr[IDX_W+1:2];
    end

    // Control bits, the delay and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_int <= 1'b0;
            single   <= 1'b0;
            dly      <= '0;
            start    <= 1'b0;
        end else begin
            start <= wr_en && hit_ctrl && wdata[0] && (!mode_int || wdata[1]);
            if (wr_en && hit_ctrl) begin
                mode_int <= wdata[0];
                single   <= wdata[1];
            end
            if (wr_en && hit_dly)
                dly <= wdata[DLY_W-1:0];
        end
    end

    // Command table storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++)
                tbl[i] <= '0;
        end else if (wr_en && hit_tbl) begin
            tbl[wr_idx] <= wdata;
        end
    end

    // Host read mux; bits that are not implemented read 0.
    always_comb begin
        rdata = '0;
        if (hit_tbl)
            rdata = tbl[wr_idx];
        else if (hit_ctrl)
            rdata = WORD_W'({single, mode_int});
        else if (hit_dly)
            rdata = WORD_W'(dly);
    end

    // Entry the sequencer is sending.
    assign seq_entry = tbl[seq_idx];

    AST_TBL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_tbl) |=> (tbl[$past(wr_idx)] == $past(wdata))); // R3

endmodule

// File: rtl/lcs_seq.sv
// Playback engine: waits the start delay, then steps through the table
// one entry per cycle. Stops for single-shot playback, loops for repeating
// playback. Assumes start is a one-cycle pulse from the register file and
// that clearing mode_int has priority over everything else.
module lcs_seq #(
    parameter int N_ENT = 32,
    parameter int DLY_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_int,
    input  logic                      single,
    input  logic                      start,
    input  logic [DLY_W-1:0]          dly,
    output logic [$clog2(N_ENT)-1:0]  idx,
    output logic                      strobe
);
    import lcs_pkg::*;

    localparam int               IDX_W = $clog2(N_ENT);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_ENT - 1);

    seq_state_t       state;
    logic [DLY_W-1:0] cnt;

    // Phase, delay counter and table index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else if (!mode_int) begin
            state <= ST_IDLE;
        end else if (start) begin
            state <= ST_WAIT;
            cnt   <= dly;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (cnt == '0) begin
                        state <= ST_SEND;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SEND: begin
                    if (idx == LAST) begin
                        state <= single ? ST_IDLE : ST_WAIT;
                        cnt   <= dly;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // A strobe goes out in every sending cycle.
    assign strobe = (state == ST_SEND);

    AST_EXT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_int |=> (state == ST_IDLE)); // R9
    AST_ORDER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && !start && state == ST_SEND && idx != LAST)
        |=> (state == ST_SEND && idx == $past(idx) + IDX_W'(1))); // R5
    AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && !start && single && state == ST_SEND && idx == LAST)
        |=> (state == ST_IDLE)); // R6
    AST_REPEAT_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && !start && !single && state == ST_SEND && idx == LAST)
        |=> (state == ST_WAIT && cnt == $past(dly))); // R8
    AST_START_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_int && start) |=> (state == ST_WAIT && cnt == $past(dly))); // R7

endmodule

// File: rtl/lcs_mux.sv
// Source selector: gives the message outputs to the sequencer in internal
// mode and to the external stream otherwise. Purely combinational, so a
// mode change shows on the outputs in the cycle after the control write.
module lcs_mux #(
    parameter int BYTE_W = 8
) (
    input  logic                  mode_int,
    input  logic                  seq_strobe,
    input  logic [2*BYTE_W-1:0]   seq_entry,
    input  logic                  ext_valid,
    input  logic [BYTE_W-1:0]     ext_sub,
    input  logic [BYTE_W-1:0]     ext_data,
    output logic                  msg_valid,
    output logic [BYTE_W-1:0]     msg_sub,
    output logic [BYTE_W-1:0]     msg_data
);
    // Select the message source.
    always_comb begin
        if (mode_int) begin
            msg_valid = seq_strobe;
            msg_sub   = seq_entry[2*BYTE_W-1:BYTE_W];
            msg_data  = seq_entry[BYTE_W-1:0];
        end else begin
            msg_valid = ext_valid;
            msg_sub   = ext_sub;
            msg_data  = ext_data;
        end
    end

endmodule

// File: rtl/local_cmd_seq.sv
// Top: local command message sequencer. Wires the register file, the
// playback engine and the source selector. Assumes a single clock domain
// and word-aligned table accesses.
module local_cmd_seq #(
    parameter int N_ENT  = 32,
    parameter int BYTE_W = 8,
    parameter int DLY_W  = 12,
    parameter int ADDR_W = $clog2(N_ENT * 8)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [2*BYTE_W-1:0]   bus_wdata,
    output logic [2*BYTE_W-1:0]   bus_rdata,
    input  logic                  ext_valid,
    input  logic [BYTE_W-1:0]     ext_sub,
    input  logic [BYTE_W-1:0]     ext_data,
    output logic                  msg_valid,
    output logic [BYTE_W-1:0]     msg_sub,
    output logic [BYTE_W-1:0]     msg_data
);
    localparam int IDX_W = $clog2(N_ENT);

    logic                 mode_int, single, start, strobe;
    logic [DLY_W-1:0]     dly;
    logic [IDX_W-1:0]     idx;
    logic [2*BYTE_W-1:0]  entry;

    lcs_regs #(.N_ENT(N_ENT), .BYTE_W(BYTE_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .mode_int(mode_int),
        .single(single), .start(start), .dly(dly), .seq_idx(idx),
        .seq_entry(entry)
    );

    lcs_seq #(.N_ENT(N_ENT), .DLY_W(DLY_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .mode_int(mode_int), .single(single),
        .start(start), .dly(dly), .idx(idx), .strobe(strobe)
    );

    lcs_mux #(.BYTE_W(BYTE_W)) mux_i (
        .mode_int(mode_int), .seq_strobe(strobe), .seq_entry(entry),
        .ext_valid(ext_valid), .ext_sub(ext_sub), .ext_data(ext_data),
        .msg_valid(msg_valid), .msg_sub(msg_sub), .msg_data(msg_data)
    );

endmodule

// File: tb/local_cmd_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: external pass-through vectors from a table, then directed tests
// for register readback, pass timing, single-shot, restart, repeat, stop
// and reset.
module local_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_sub = '0, ext_data = '0;
    logic        msg_valid;
    logic [7:0]  msg_sub, msg_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    local_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_valid(ext_valid),
        .ext_sub(ext_sub), .ext_data(ext_data), .msg_valid(msg_valid),
        .msg_sub(msg_sub), .msg_data(msg_data)
    );

    // {ext_valid, ext_sub, ext_data}; the outputs must match in external mode.
    localparam logic [16:0] EXT_VEC [8] = '{
        17'h1_A5_3C, 17'h0_00_00, 17'h1_FF_FF, 17'h0_12_34,
        17'h1_80_01, 17'h1_01_80, 17'h0_FF_00, 17'h1_5A_C3
    };

    function automatic logic [15:0] ent(int k);
        logic [15:0] w;
        w[15:8] = 8'(k * 7 + 17);
        w[7:0]  = 8'(165 ^ k);
        return w;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic next_slot();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, 32'(bus_rdata), 32'(exp));
    endtask

    // d+1 quiet slots, then n strobes carrying entries 0..n-1.
    task automatic check_stream(string tag, int d, int n);
        for (int s = 0; s < d + 1; s++) begin
            next_slot();
            check({tag, " gap"}, 32'(msg_valid), 32'd0);
        end
        for (int k = 0; k < n; k++) begin
            next_slot();
            check({tag, " strobe"}, 32'(msg_valid), 32'd1);
            check({tag, " entry"}, {16'h0, msg_sub, msg_data}, 32'(ent(k)));
        end
    endtask

    // Called right after a start write: the slot after the write edge is skipped.
    task automatic check_pass(string tag, int d, int n);
        #1;
        check_stream(tag, d, n);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_check("R1 ctrl", 8'h00, 16'h0000);
        rd_check("R1 delay", 8'h04, 16'h0000);
        rd_check("R1 table", 8'h94, 16'h0000);

        // R2: external pass-through, vector table
        foreach (EXT_VEC[i]) begin
            @(negedge clk);
            {ext_valid, ext_sub, ext_data} = EXT_VEC[i];
            #1;
            check("R2 ext follow", {15'h0, msg_valid, msg_sub, msg_data}, 32'(EXT_VEC[i]));
        end

        // R3: load and read back the table, delay masking, ctrl bits
        for (int k = 0; k < 32; k++) wr(8'(8'h80 + 4 * k), ent(k));
        for (int k = 0; k < 32; k++) rd_check("R3 table", 8'(8'h80 + 4 * k), ent(k));
        wr(8'h04, 16'hFFFF);
        rd_check("R3 delay mask", 8'h04, 16'h0FFF);
        wr(8'h04, 16'd3);
        rd_check("R3 delay", 8'h04, 16'd3);
        wr(8'h00, 16'hFFF2);
        rd_check("R3 ctrl mask", 8'h00, 16'h0002);
        check("R2 still ext", 32'(msg_valid), 32'(ext_valid));

        // R4 R5: single-shot pass on entering internal mode
        ext_valid = 1'b1;
        wr(8'h00, 16'h0003);
        check_pass("R4 R5 single", 3, 32);

        // R6: idle afterwards, external strobes do not leak through
        for (int s = 0; s < 40; s++) begin
            next_slot();
            check("R6 idle", 32'(msg_valid), 32'd0);
        end

        // R7: start request, then restart mid-pass with a new delay
        wr(8'h04, 16'd0);
        wr(8'h00, 16'h0003);
        check_pass("R7 start", 0, 10);
        wr(8'h04, 16'd5);
        wr(8'h00, 16'h0003);
        check_pass("R7 restart", 5, 32);

        // R8: repeating playback loops with the gap
        wr(8'h00, 16'h0000);
        wr(8'h04, 16'd2);
        wr(8'h00, 16'h0001);
        check_pass("R8 first", 2, 32);
        check_stream("R8 loop", 2, 32);
        check_stream("R8 loop2", 2, 5);

        // R9: clearing internal mode stops at once
        ext_valid = 1'b1; ext_sub = 8'h3E; ext_data = 8'h71;
        wr(8'h00, 16'h0000);
        #1;
        check("R9 stop", {15'h0, msg_valid, msg_sub, msg_data}, 32'h1_3E71);
        ext_valid = 1'b0;
        for (int s = 0; s < 5; s++) begin
            next_slot();
            check("R9 ext after stop", 32'(msg_valid), 32'd0);
        end

        // R1: reset mid-run returns to the default state
        wr(8'h00, 16'h0001);
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ext_valid = 1'b0;
        #1;
        check("R1 reset out", 32'(msg_valid), 32'd0);
        rd_check("R1 reset ctrl", 8'h00, 16'h0000);
        rd_check("R1 reset table", 8'h80, 16'h0000);
        rd_check("R1 reset delay", 8'h04, 16'h0000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule